// File: doc/BRIEF.md
# Dual-Bit Write SPI Master

This block is a byte-oriented SPI master that drives a serial clock, a data output, two chip-select lines and an auxiliary output, and reads one data input. A host hands it one byte at a time over a request/acknowledge interface. Each request carries the byte, a flag that selects single-bit or dual-bit (fast-write) shifting, a chip-select index, a polarity option and an end-of-frame flag. Each finished byte returns what was sampled on the input line. The serial clock idles low.

In fast-write mode every clock carries two data bits: the higher bit of each pair on the data output and the lower bit on the auxiliary line. A byte then needs four clocks instead of eight. A verify option sends zeros and compares the returned byte with the byte supplied. A mismatch ends the frame and reports the position of the failing byte within the frame. The clock divider setting is forced to at least 1, and it is taken only while the block is idle.

Top module: `spi_dw_master`

## Requirements
- R1: In single-bit mode a byte takes exactly 8 SCK rising edges, and `mosi` carries the byte most-significant bit first, one bit per edge. `aux` stays low throughout.
- R2: In fast-write mode a byte takes exactly 4 SCK rising edges. Edge k (k = 0..3) carries bit 7-2k on `mosi` and bit 6-2k on `aux`. Whenever `busy` is low, `aux` is low.
- R3: `mosi` and `aux` change only while SCK is low, and they hold steady for the whole high phase.
- R4: Both `cs_n` bits idle high. With `req_cs_high`=0, index 2 pulls `cs_n[1]` low (cs_n=2'b01) and any other index pulls `cs_n[0]` low (cs_n=2'b10). With `req_cs_high`=1 both stay high. The two bits are never low together.
- R5: The select stays asserted between bytes of a frame. After the byte that ends a frame, both selects go high, and `busy` stays high for exactly GAP_CYC clock cycles, beginning with the cycle in which `done` is high. GAP_CYC defaults to 20 cycles, which is 100 ns at 200 MHz.
- R6: The effective divider is max(`div_cfg`, 1). Each SCK high phase and each low phase between edges lasts effective divider + 1 system clocks.
- R7: `div_cfg` is loaded only while the block is idle. Changing it during a byte has no effect on that byte's timing.
- R8: `miso` is sampled at each SCK rising edge and shifted in MSB first from zero. `rx_byte` holds all 8 samples in single-bit mode and {4'b0000, 4 samples} in fast-write mode.
- R9: With `req_verify`=1 the block transmits 8'h00 and compares `rx_byte` with `req_byte`. On a mismatch, `mismatch`=1, `fail_idx` is the 0-based position of the byte within the frame, and the frame ends as in R5. A matching byte leaves `mismatch`=0.
- R10: `busy` rises on the cycle after a request is accepted and falls after `done`, which is a single-cycle pulse (on a byte that does not end a frame, `busy` is already low in the `done` cycle). Requests presented while `busy` is high are ignored.
- R11: Synchronous active-high reset drives SCK low, both selects high, `aux` low and `busy` low, and abandons any byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Clock divider setting, taken while idle |
| req_valid | input | 1 | Byte request, accepted when not busy |
| req_byte | input | 8 | Byte to send, or expected byte in verify mode |
| req_fast | input | 1 | 1 = two bits per SCK clock |
| req_cs | input | 2 | Chip-select index |
| req_cs_high | input | 1 | Polarity option: keep both selects high |
| req_last | input | 1 | Byte ends the frame |
| req_verify | input | 1 | Send zeros and compare the returned byte |
| busy | output | 1 | Byte or trailing gap in progress |
| done | output | 1 | One-cycle pulse when a byte finishes |
| rx_byte | output | 8 | Byte sampled on `miso` |
| mismatch | output | 1 | Verify comparison failed on the last byte |
| fail_idx | output | IDX_W | Position of the failing byte in its frame |
| miso | input | 1 | Serial data input |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data output |
| aux | output | 1 | Second data bit in fast-write mode |
| cs_n | output | 2 | Chip-select lines |

## Verification
On every cycle the assertions check four things: the two selects are never low together, data lines hold still through each SCK high phase, `aux` is quiet when idle and selects are released during the trailing gap, and `done` is a single pulse with SCK rising only while busy. The reset state is also checked each cycle. Bit ordering in both modes, select mapping, divider timing, the sampled input byte, mismatch position and the length of the trailing gap depend on what the host requested. These the bench scenarios show by capturing the bus at each SCK edge and comparing against values it computes itself.

// File: rtl/spi_dw_pkg.sv
package spi_dw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } dw_state_e;

  localparam int BYTE_W      = 8;
  localparam int CLK_SINGLE  = 8;
  localparam int CLK_DUAL    = 4;

  // Divider setting actually used: zero is not allowed (first sampled bit is unreliable)
  function automatic int unsigned eff_div(input int unsigned setting);
    return (setting < 1) ? 1 : setting;
  endfunction

  // Number of SCK clocks that carry one byte
  function automatic int unsigned clocks_per_byte(input logic dual);
    return dual ? CLK_DUAL : CLK_SINGLE;
  endfunction

  // Select levels for one request; ALT_IDX picks the second line
  function automatic logic [1:0] select_level(input logic [1:0] idx,
                                               input logic pol_high,
                                               input int unsigned alt_idx);
    if (pol_high)                      return 2'b11;
    else if (int'(idx) == int'(alt_idx)) return 2'b01;
    else                               return 2'b10;
  endfunction

endpackage

// File: rtl/spi_dw_clkdiv.sv
module spi_dw_clkdiv
  import spi_dw_pkg::*;
#(
  parameter int DIV_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             run,
  output logic             half_end
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign half_end = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      if (load_en)
        div_q <= DIV_W'(eff_div(int'(div_cfg)));
      if (!run || half_end)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_dw_csel.sv
module spi_dw_csel
  import spi_dw_pkg::*;
#(
  parameter int ALT_IDX = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] idx,
  input  logic       pol_high,
  input  logic       release_all,
  output logic [1:0] cs_n
);

  logic [1:0] next_lvl;

  always_comb next_lvl = select_level(idx, pol_high, ALT_IDX);

  always_ff @(posedge clk) begin
    if (rst)
      cs_n <= 2'b11;
    else if (release_all)
      cs_n <= 2'b11;
    else if (load)
      cs_n <= next_lvl;
  end

endmodule

// File: rtl/spi_dw_shifter.sv
module spi_dw_shifter
  import spi_dw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              dual,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi_bit,
  output logic              aux_bit,
  output logic              last_clk,
  output logic              dual_q,
  output logic [BYTE_W-1:0] rx_data
);

  localparam int LEFT_W = $clog2(CLK_SINGLE + 1);

  logic [BYTE_W-1:0] tx_sr;
  logic [LEFT_W-1:0] left_q;

  assign mosi_bit = tx_sr[BYTE_W-1];
  assign aux_bit  = dual_q & tx_sr[BYTE_W-2];
  assign last_clk = (left_q == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_data <= '0;
      left_q  <= '0;
      dual_q  <= 1'b0;
    end else if (load) begin
      tx_sr   <= tx_byte;
      rx_data <= '0;
      left_q  <= LEFT_W'(clocks_per_byte(dual));
      dual_q  <= dual;
    end else begin
      if (sample)
        rx_data <= {rx_data[BYTE_W-2:0], miso};
      if (shift) begin
        tx_sr  <= dual_q ? {tx_sr[BYTE_W-3:0], 2'b00} : {tx_sr[BYTE_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_dw_master.sv
module spi_dw_master
  import spi_dw_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 20,
  parameter int IDX_W   = 8,
  parameter int ALT_IDX = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             req_valid,
  input  logic [7:0]       req_byte,
  input  logic             req_fast,
  input  logic [1:0]       req_cs,
  input  logic             req_cs_high,
  input  logic             req_last,
  input  logic             req_verify,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             mismatch,
  output logic [IDX_W-1:0] fail_idx,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             aux,
  output logic [1:0]       cs_n
);

  localparam int GW = $clog2(GAP_CYC + 1);

  dw_state_e         state_q;
  logic              sck_q;
  logic [7:0]        exp_q;
  logic              verify_q;
  logic              last_q;
  logic              done_q;
  logic [7:0]        rx_q;
  logic              mism_q;
  logic [IDX_W-1:0]  fidx_q;
  logic [IDX_W-1:0]  frame_idx_q;
  logic [GW-1:0]     gcnt_q;

  // named internal events, also watched by the checker
  logic accept, run, half_end, byte_end, miss_now, frame_end;
  logic in_gap, sample_now, shift_now;
  logic mosi_bit, aux_bit, last_clk, dual_q;
  logic [7:0] rx_data;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign run        = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign sample_now = (state_q == ST_LOW) && half_end;
  assign shift_now  = (state_q == ST_HIGH) && half_end && !last_clk;
  assign byte_end   = (state_q == ST_HIGH) && half_end && last_clk;
  assign miss_now   = verify_q && (rx_data != exp_q);
  assign frame_end  = byte_end && (last_q || miss_now);
  assign in_gap     = (state_q == ST_GAP);

  spi_dw_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (state_q == ST_IDLE),
    .div_cfg  (div_cfg),
    .run      (run),
    .half_end (half_end)
  );

  spi_dw_csel #(.ALT_IDX(ALT_IDX)) csel_i (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .idx         (req_cs),
    .pol_high    (req_cs_high),
    .release_all (frame_end),
    .cs_n        (cs_n)
  );

  spi_dw_shifter shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .tx_byte  (req_verify ? 8'h00 : req_byte),
    .dual     (req_fast),
    .shift    (shift_now),
    .sample   (sample_now),
    .miso     (miso),
    .mosi_bit (mosi_bit),
    .aux_bit  (aux_bit),
    .last_clk (last_clk),
    .dual_q   (dual_q),
    .rx_data  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sck_q       <= 1'b0;
      exp_q       <= '0;
      verify_q    <= 1'b0;
      last_q      <= 1'b0;
      done_q      <= 1'b0;
      rx_q        <= '0;
      mism_q      <= 1'b0;
      fidx_q      <= '0;
      frame_idx_q <= '0;
      gcnt_q      <= '0;
    end else begin
      done_q <= byte_end;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_LOW;
            exp_q    <= req_byte;
            verify_q <= req_verify;
            last_q   <= req_last;
            mism_q   <= 1'b0;
          end
        end
        ST_LOW: begin
          if (half_end) begin
            state_q <= ST_HIGH;
            sck_q   <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (half_end) begin
            sck_q <= 1'b0;
            if (last_clk) begin
              rx_q   <= rx_data;
              mism_q <= miss_now;
              if (miss_now)
                fidx_q <= frame_idx_q;
              if (frame_end) begin
                state_q     <= ST_GAP;
                gcnt_q      <= '0;
                frame_idx_q <= '0;
              end else begin
                state_q     <= ST_IDLE;
                frame_idx_q <= frame_idx_q + 1'b1;
              end
            end else begin
              state_q <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (gcnt_q == GW'(GAP_CYC - 1))
            state_q <= ST_IDLE;
          else
            gcnt_q <= gcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rx_byte  = rx_q;
  assign mismatch = mism_q;
  assign fail_idx = fidx_q;
  assign sck      = sck_q;
  assign mosi     = run ? mosi_bit : 1'b0;
  assign aux      = run ? aux_bit  : 1'b0;

endmodule

// File: rtl/spi_dw_checker.sv
module spi_dw_checker (
  input logic       clk,
  input logic       rst,
  input logic       sck,
  input logic       mosi,
  input logic       aux,
  input logic [1:0] cs_n,
  input logic       busy,
  input logic       done,
  input logic       in_gap
);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> ($stable(mosi) && $stable(aux)));

  assert_aux_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !aux);

  assert_cs_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n != 2'b00);

  assert_gap_release_R5: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> (cs_n == 2'b11));

  assert_sck_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (!sck && (cs_n == 2'b11) && !aux && !busy));

endmodule

bind spi_dw_master spi_dw_checker chk_i (.*);

// File: tb/spi_dw_master_tb.sv
`timescale 1ns/1ps
module spi_dw_master_tb_top;

  localparam int DIV_W   = 8;
  localparam int GAP_CYC = 20;
  localparam int IDX_W   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_cfg = '0;
  logic             req_valid = 1'b0;
  logic [7:0]       req_byte = '0;
  logic             req_fast = 1'b0;
  logic [1:0]       req_cs = '0;
  logic             req_cs_high = 1'b0;
  logic             req_last = 1'b0;
  logic             req_verify = 1'b0;
  logic             busy, done, mismatch, sck, mosi, aux, miso;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] fail_idx;
  logic [1:0]       cs_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // slave model and bus monitor state
  logic [7:0] slv_resp = '0;
  logic [2:0] slv_ptr = '0;
  logic [7:0] cap_mosi, cap_aux;
  int         cap_n = 0;
  logic [1:0] exp_cs_v = 2'b11;
  int         exp_half = 2;
  bit         cs_bad, hi_bad, lo_bad, r3_bad;
  realtime    t_rise = 0, t_fall = 0;
  logic       prev_sck = 1'b0, hold_mosi = 1'b0, hold_aux = 1'b0;
  int         fr_idx = 0;

  always #2.5 clk = ~clk;

  assign miso = slv_resp[3'd7 - slv_ptr];

  spi_dw_master #(.DIV_W(DIV_W), .GAP_CYC(GAP_CYC), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .req_valid(req_valid),
    .req_byte(req_byte), .req_fast(req_fast), .req_cs(req_cs),
    .req_cs_high(req_cs_high), .req_last(req_last), .req_verify(req_verify),
    .busy(busy), .done(done), .rx_byte(rx_byte), .mismatch(mismatch),
    .fail_idx(fail_idx), .miso(miso), .sck(sck), .mosi(mosi), .aux(aux),
    .cs_n(cs_n)
  );

  always @(posedge sck) begin
    cap_mosi = {cap_mosi[6:0], mosi};
    cap_aux  = {cap_aux[6:0], aux};
    if (cs_n !== exp_cs_v) cs_bad = 1;
    if (cap_n > 0 && int'(($realtime - t_fall) / 5.0) != exp_half) lo_bad = 1;
    cap_n++;
    t_rise = $realtime;
  end

  always @(negedge sck) begin
    if (int'(($realtime - t_rise) / 5.0) != exp_half) hi_bad = 1;
    t_fall = $realtime;
    slv_ptr = slv_ptr + 3'd1;
  end

  always @(negedge clk) begin
    if (sck && prev_sck && (mosi !== hold_mosi || aux !== hold_aux)) r3_bad = 1;
    hold_mosi = mosi;
    hold_aux  = aux;
    prev_sck  = sck;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cs_exp(input logic [1:0] idx, input bit pol);
    if (pol) return 2'b11;
    return (idx == 2'd2) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [3:0] even_bits(input logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction

  function automatic logic [3:0] odd_bits(input logic [7:0] b);
    return {b[6], b[4], b[2], b[0]};
  endfunction

  task automatic do_byte(input logic [7:0] b, input bit fast, input logic [1:0] idx,
                         input bit pol, input bit last, input bit vfy,
                         input logic [7:0] resp, input int dcfg,
                         input bit inject, input bit chg_div);
    int dexp, n;
    logic [7:0] txe, rxe;
    bit miss, ends;
    dexp = (dcfg < 1) ? 1 : dcfg;
    exp_half = dexp + 1;
    exp_cs_v = cs_exp(idx, pol);
    slv_resp = resp; slv_ptr = '0;
    cap_n = 0; cap_mosi = '0; cap_aux = '0;
    cs_bad = 0; hi_bad = 0; lo_bad = 0; r3_bad = 0;
    div_cfg = DIV_W'(dcfg);
    while (busy) @(negedge clk);
    req_byte = b; req_fast = fast; req_cs = idx; req_cs_high = pol;
    req_last = last; req_verify = vfy; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (inject || chg_div) begin
      while (cap_n < 1) @(negedge clk);
      if (chg_div) div_cfg = DIV_W'(dcfg + 3);
      if (inject) begin
        req_byte = ~b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    while (!done) @(negedge clk);
    txe  = vfy ? 8'h00 : b;
    rxe  = fast ? {4'b0000, resp[7:4]} : resp;
    miss = vfy && (rxe != b);
    ends = last || miss;
    if (fast) begin
      check(cap_n == 4, "R2 clock count", cap_n, 4);
      check(cap_mosi[3:0] == even_bits(txe), "R2 mosi bits", cap_mosi[3:0], even_bits(txe));
      check(cap_aux[3:0] == odd_bits(txe), "R2 aux bits", cap_aux[3:0], odd_bits(txe));
    end else begin
      check(cap_n == 8, "R1 clock count", cap_n, 8);
      check(cap_mosi == txe, "R1 mosi bits", cap_mosi, txe);
      check(cap_aux == 8'h00, "R2 aux quiet in single mode", cap_aux, 0);
    end
    check(!r3_bad, "R3 data held while SCK high", r3_bad, 0);
    check(rx_byte == rxe, "R8 sampled byte", rx_byte, rxe);
    check(!cs_bad, "R4 select level during clocks", cs_bad, 0);
    if (chg_div)
      check(!hi_bad && !lo_bad, "R7 divider frozen during byte", hi_bad | lo_bad, 0);
    else
      check(!hi_bad && !lo_bad, "R6 SCK phase length", hi_bad | lo_bad, 0);
    if (vfy) begin
      check(mismatch == miss, "R9 mismatch flag", mismatch, miss);
      if (miss) check(fail_idx == IDX_W'(fr_idx), "R9 failing index", fail_idx, fr_idx);
    end
    if (ends) begin
      check(cs_n == 2'b11, "R5 selects released at frame end", cs_n, 2'b11);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check(n == GAP_CYC, "R5 gap length", n, GAP_CYC);
      fr_idx = 0;
    end else begin
      check(busy == 1'b0, "R10 idle at done", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R10 done is one pulse", done, 0);
      check(cs_n == exp_cs_v, "R5 select held inside frame", cs_n, exp_cs_v);
      fr_idx++;
    end
    if (inject) begin
      n = cap_n;
      repeat (8) @(negedge clk);
      check(cap_n == n && !busy, "R10 request while busy ignored", cap_n, n);
    end
    if (chg_div) div_cfg = DIV_W'(dcfg);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(sck == 0 && cs_n == 2'b11 && aux == 0 && busy == 0, "R11 reset state",
          {sck, cs_n, aux, busy}, 5'b01100);
    rst = 1'b0;
    @(negedge clk);
    // directed corner cases
    do_byte(8'hA5, 0, 2'd0, 0, 0, 0, 8'h3C, 0, 0, 0);   // minimum divider
    do_byte(8'h5A, 0, 2'd0, 0, 1, 0, 8'hC3, 1, 0, 0);
    do_byte(8'hB4, 1, 2'd2, 0, 1, 0, 8'h96, 2, 0, 0);   // fast write, second line
    do_byte(8'h69, 0, 2'd2, 1, 1, 0, 8'h11, 3, 0, 0);   // polarity option
    do_byte(8'hC7, 1, 2'd3, 0, 1, 0, 8'hE1, 1, 0, 0);   // index 3 maps to first line
    do_byte(8'h81, 0, 2'd1, 0, 0, 0, 8'h7E, 1, 1, 0);   // injected request
    do_byte(8'h7E, 0, 2'd1, 0, 1, 0, 8'h81, 1, 0, 0);
    do_byte(8'h33, 0, 2'd0, 0, 1, 0, 8'h0F, 2, 0, 1);   // divider changed mid-byte
    do_byte(8'h3C, 0, 2'd0, 0, 0, 1, 8'h3C, 1, 0, 0);   // verify match
    do_byte(8'h55, 0, 2'd0, 0, 0, 1, 8'h54, 1, 0, 0);   // verify mismatch at index 1
    do_byte(8'h0F, 0, 2'd2, 0, 0, 1, 8'hF0, 1, 0, 0);   // mismatch at index 0
    // reset in the middle of a byte (R11)
    while (busy) @(negedge clk);
    req_byte = 8'hFF; req_fast = 0; req_cs = 2'd0; req_cs_high = 0;
    req_last = 0; req_verify = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(sck == 0 && cs_n == 2'b11 && aux == 0 && busy == 0, "R11 reset mid-byte",
          {sck, cs_n, aux, busy}, 5'b01100);
    fr_idx = 0;
    // constrained random traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b, r;
      bit f, p, l, v;
      b = 8'($urandom);
      f = ($urandom % 2) == 0;
      p = ($urandom % 8) == 0;
      l = ($urandom % 3) == 0 || i == 39;
      v = !f && (($urandom % 6) == 0);
      r = v ? ((($urandom % 2) == 0) ? b : b ^ 8'(1 << ($urandom % 8))) : 8'($urandom);
      do_byte(b, f, 2'($urandom), p, l, v, r, int'($urandom % 5), 0, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule